// File: doc/BRIEF.md
# One-Hot Sum-of-Products Word Selector

This block picks one of `2**SEL_W` data words of `DATA_W` bits each and drives it onto a single output word. It is purely combinational and has no clock. It is meant for datapaths where AND-type gates cost much more than XOR gates. In that setting the number of AND levels, not the number of gates, sets the evaluation time.

Instead of a chain of 2:1 selector stages, the select bus is first decoded into one product term per input word. The term for index `i` is true only when the select value equals `i`. The decoder splits the select bits into a low half and a high half and decodes each half recursively. Each full term is then one AND of a low-half term and a high-half term. Every partial product is therefore built once and shared by all terms that contain it.

Each term gates its own data word. The gated words are merged with XOR rather than OR. This is exact because at most one term can be true at a time. The AND depth grows as the logarithm of `SEL_W`, not of the word count. The decoder cost does not depend on `DATA_W`.

Top module: `onehot_dnf_mux`

## Requirements
- R1: For every select value `s`, `word_o` equals data word `s`. Word `i` occupies bits `[i*DATA_W +: DATA_W]` of `data_i`, and bit 0 of `sel_i` is the least significant select bit.
- R2: For any known select value, exactly one decoded product term is asserted.
- R3: The term for index `i` is asserted exactly when `sel_i == i`. At the ports, if only word `j` is nonzero, the output is nonzero exactly when `sel_i == j`.
- R4: A word whose term is low contributes zero to the merge. Changing any data word other than word `sel_i` leaves `word_o` unchanged.
- R5: `word_o` equals the result of a reference tree of 2:1 stages. Stage level `k` is steered by select bit `k` and computes `((a ^ b) & c) ^ a`, where `a` is the even-indexed operand and `b` is the odd-indexed operand.
- R6: The boundary selects 0 and `2**SEL_W - 1`, and the data patterns all-zeros, all-ones and alternating bits, give the selected word unchanged.
- R7: `word_o` follows a change of `sel_i` or `data_i` in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 2**SEL_W * DATA_W | Packed data words, word i at bits [i*DATA_W +: DATA_W] |
| sel_i | input | SEL_W | Binary select value, bit 0 least significant |
| word_o | output | DATA_W | The selected data word |

## Verification
The two functions that can act at the same moment are the re-steering of the decoded terms when the select changes and the propagation of new data through the product plane. The bench provokes this overlap by changing the select value and rewriting every unselected word in one step. It then samples after a short settle delay with no clock edge in between. The result is judged against both direct indexing and the 2:1 tree model. Isolation sweeps, where only one word is nonzero, show at the ports whether a stale or doubled term leaks another word into the XOR merge.

// File: rtl/dnfmux_pkg.sv
package dnfmux_pkg;

    // Width of the lower half when a select field is split for recursive decoding.
    function automatic int unsigned lo_half(input int unsigned w);
        return w / 2;
    endfunction

    // Width of the upper half, which takes the extra bit when the width is odd.
    function automatic int unsigned hi_half(input int unsigned w);
        return w - (w / 2);
    endfunction

endpackage

// File: rtl/dnf_sel_decode.sv
module dnf_sel_decode #(
    parameter int unsigned SEL_W = 4
) (
    input  logic [SEL_W-1:0]        sel_i,
    output logic [(1<<SEL_W)-1:0]   term_o
);
    localparam int unsigned NUM = 1 << SEL_W;

    generate
        if (SEL_W == 1) begin : g_leaf
            assign term_o = {sel_i[0], ~sel_i[0]};
        end else begin : g_split
            localparam int unsigned LO_W  = dnfmux_pkg::lo_half(SEL_W);
            localparam int unsigned HI_W  = dnfmux_pkg::hi_half(SEL_W);
            localparam int unsigned LO_N  = 1 << LO_W;
            localparam int unsigned HI_N  = 1 << HI_W;

            logic [LO_N-1:0] lo_term;
            logic [HI_N-1:0] hi_term;

            dnf_sel_decode #(.SEL_W(LO_W)) u_lo (
                .sel_i  (sel_i[LO_W-1:0]),
                .term_o (lo_term)
            );

            dnf_sel_decode #(.SEL_W(HI_W)) u_hi (
                .sel_i  (sel_i[SEL_W-1:LO_W]),
                .term_o (hi_term)
            );

            for (genvar i = 0; i < NUM; i++) begin : g_term
                assign term_o[i] = lo_term[i % LO_N] & hi_term[i / LO_N];
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown(sel_i)) begin
            AST_TERMS_ONEHOT: assert ($countones(term_o) == 1)  // R2
                else $error("decoded terms not one-hot");
            AST_TERM_AT_SEL: assert (term_o[sel_i] == 1'b1)  // R3
                else $error("term for select index not asserted");
        end
    end

endmodule

// File: rtl/dnf_and_plane.sv
module dnf_and_plane #(
    parameter int unsigned NUM    = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic [NUM-1:0]                 term_i,
    input  logic [NUM*DATA_W-1:0]          data_i,
    output logic [NUM-1:0][DATA_W-1:0]     prod_o
);
    generate
        for (genvar i = 0; i < NUM; i++) begin : g_word
            assign prod_o[i] = data_i[i*DATA_W +: DATA_W] & {DATA_W{term_i[i]}};
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            if (term_i[i] === 1'b0) begin
                AST_IDLE_PROD_ZERO: assert (prod_o[i] == '0)  // R4
                    else $error("unselected product not zero");
            end
        end
    end

endmodule

// File: rtl/dnf_xor_merge.sv
module dnf_xor_merge #(
    parameter int unsigned NUM    = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic [NUM-1:0][DATA_W-1:0] prod_i,
    output logic [DATA_W-1:0]          word_o
);
    logic [DATA_W-1:0] acc_d;

    always_comb begin
        acc_d = '0;
        for (int i = 0; i < NUM; i++) begin
            acc_d = acc_d ^ prod_i[i];
        end
    end

    assign word_o = acc_d;

endmodule

// File: rtl/onehot_dnf_mux.sv
module onehot_dnf_mux #(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic [(1<<SEL_W)*DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0]             sel_i,
    output logic [DATA_W-1:0]            word_o
);
    localparam int unsigned NUM = 1 << SEL_W;

    logic [NUM-1:0]              term;
    logic [NUM-1:0][DATA_W-1:0]  prod;

    dnf_sel_decode #(.SEL_W(SEL_W)) u_decode (
        .sel_i  (sel_i),
        .term_o (term)
    );

    dnf_and_plane #(.NUM(NUM), .DATA_W(DATA_W)) u_plane (
        .term_i (term),
        .data_i (data_i),
        .prod_o (prod)
    );

    dnf_xor_merge #(.NUM(NUM), .DATA_W(DATA_W)) u_merge (
        .prod_i (prod),
        .word_o (word_o)
    );

    always_comb begin
        if (!$isunknown(sel_i) && !$isunknown(data_i)) begin
            AST_OUT_IS_SELECTED: assert (word_o == data_i[sel_i*DATA_W +: DATA_W])  // R1
                else $error("output differs from selected word");
        end
    end

endmodule

// File: tb/onehot_dnf_mux_bench.sv
module onehot_dnf_mux_bench;
    localparam int unsigned SEL_W  = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NUM    = 1 << SEL_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NUM*DATA_W-1:0] data;
    logic [SEL_W-1:0]      sel;
    logic [DATA_W-1:0]     word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    onehot_dnf_mux #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_onehot_dnf_mux (
        .data_i (data),
        .sel_i  (sel),
        .word_o (word)
    );

    function automatic logic [DATA_W-1:0] pick(input logic [NUM*DATA_W-1:0] d,
                                               input logic [SEL_W-1:0] s);
        return d[s*DATA_W +: DATA_W];
    endfunction

    function automatic logic [DATA_W-1:0] tree_model(input logic [NUM*DATA_W-1:0] d,
                                                     input logic [SEL_W-1:0] s);
        logic [DATA_W-1:0] lvl [NUM];
        for (int i = 0; i < NUM; i++) lvl[i] = d[i*DATA_W +: DATA_W];
        for (int k = 0; k < SEL_W; k++) begin
            for (int j = 0; j < (NUM >> (k+1)); j++) begin
                lvl[j] = ((lvl[2*j] ^ lvl[2*j+1]) & {DATA_W{s[k]}}) ^ lvl[2*j];
            end
        end
        return lvl[0];
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, got, exp);
        end
    endtask

    task automatic apply(input logic [NUM*DATA_W-1:0] d, input logic [SEL_W-1:0] s);
        @(posedge clk);
        data = d;
        sel  = s;
        @(negedge clk);
    endtask

    task automatic sweep(input logic [NUM*DATA_W-1:0] d, input string req);
        for (int s = 0; s < NUM; s++) begin
            apply(d, SEL_W'(s));
            check(req, word, pick(d, SEL_W'(s)));         // R1 direct index
            check("R5", word, tree_model(d, SEL_W'(s)));  // R5 tree model
        end
    endtask

    initial begin
        logic [NUM*DATA_W-1:0] d;
        data = '0;
        sel  = '0;
        @(negedge clk);
        check("R6", word, '0);  // R6 all-zero data at select 0

        // R1/R5: random data words
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < NUM; i++) d[i*DATA_W +: DATA_W] = DATA_W'($urandom);
            sweep(d, "R1");
        end

        // R1: index-coded words
        for (int i = 0; i < NUM; i++) d[i*DATA_W +: DATA_W] = DATA_W'(i*17 + 3);
        sweep(d, "R1");

        // R6: all ones, alternating, boundary selects
        sweep({NUM*DATA_W{1'b1}}, "R6");
        sweep({(NUM*DATA_W/2){2'b10}}, "R6");
        apply({NUM*DATA_W{1'b1}}, '0);
        check("R6", word, {DATA_W{1'b1}});
        apply({(NUM*DATA_W/2){2'b01}}, SEL_W'(NUM-1));
        check("R6", word, {(DATA_W/2){2'b01}});

        // R2/R3: only word j nonzero, output nonzero exactly when sel == j
        for (int j = 0; j < NUM; j++) begin
            d = '0;
            d[j*DATA_W +: DATA_W] = {DATA_W{1'b1}};
            for (int s = 0; s < NUM; s++) begin
                apply(d, SEL_W'(s));
                check("R3", word, (s == j) ? {DATA_W{1'b1}} : '0);
            end
        end

        // R4: rewrite every unselected word, output must hold
        for (int s = 0; s < NUM; s++) begin
            for (int i = 0; i < NUM; i++) d[i*DATA_W +: DATA_W] = DATA_W'($urandom);
            apply(d, SEL_W'(s));
            for (int i = 0; i < NUM; i++)
                if (i != s) d[i*DATA_W +: DATA_W] = ~d[i*DATA_W +: DATA_W];
            @(posedge clk);
            data = d;
            @(negedge clk);
            check("R4", word, pick(d, SEL_W'(s)));
        end

        // R7: select and unselected data change together, sampled with no clock edge
        @(negedge clk);
        for (int s = 0; s < NUM; s++) begin
            for (int i = 0; i < NUM; i++) d[i*DATA_W +: DATA_W] = DATA_W'($urandom);
            data = d;
            sel  = SEL_W'(NUM - 1 - s);
            #1;
            check("R7", word, pick(d, SEL_W'(NUM - 1 - s)));
            check("R7", word, tree_model(d, SEL_W'(NUM - 1 - s)));
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 50000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule